// File: doc/BRIEF.md
# Paged bus address and modifier composer

This block sits between a CPU and a 32-bit system bus master. When a CPU access falls inside a 64 KB window, the block builds the full bus cycle description. The low 16 address bits come straight from the CPU offset. The upper 16 bits are spliced together from three software-programmed registers: an 8-bit top page, a 2-bit field inside a modifier register, and a 6-bit middle page. The same modifier register supplies four of the six address-modifier bits, a byte-order select and an interrupt-acknowledge flag. The remaining two modifier bits come from hardware inputs that give the privilege level and the program/data kind of the access.

The data lanes are either passed through or byte-reversed across the 32-bit word, depending on the byte-order select. The byte enables follow their bytes. The composed cycle is registered and presented one clock after the window hit. Bus arbitration and the transfer handshake are handled elsewhere.

Top module: `pgbus_compose`

## Requirements
- R1: After a synchronous active-low reset, all three registers read 0, `bus_valid` is 0, and `bus_addr`, `bus_am`, `bus_data`, `bus_be`, `bus_iack` and `bus_big` are all 0.
- R2: A write with `reg_sel`=0 loads the top page register, and a write with `reg_sel`=1 loads the modifier register. `rd_data` for `rd_sel` 0 or 1 returns, in the same cycle and without a clock, the last value written to that register.
- R3: Selectors 2, 3 and 4 all reach the same middle page register. A write through any of them is visible on a read through any of them.
- R4: Writes with `reg_sel` 5, 6 or 7 change no register, and reads with `rd_sel` 5, 6 or 7 return 0.
- R5: `bus_valid` is high exactly in the cycle after a cycle with `cpu_hit` high. The outputs are captured at that edge from the register values in effect before any write in the same cycle. Without a hit, the address, modifier and data outputs hold their values.
- R6: `bus_addr` = {top page[7:0], modifier[7:6], middle page[5:0], `cpu_addr`[15:0]}.
- R7: `bus_am` bit 5 = modifier[3], bit 4 = modifier[2], bit 3 = `cpu_super`, bit 2 = modifier[1], bit 1 = modifier[0], bit 0 = `cpu_prog`.
- R8: With modifier[5]=0 (little-endian), each lane whose enable is set passes its byte unchanged, `bus_be` equals `cpu_be`, and lanes that are not enabled drive 0.
- R9: With modifier[5]=1, output lane i carries input lane 3-i and `bus_be[i]`=`cpu_be[3-i]`. Lanes whose enable is clear drive 0. `bus_big` shows modifier[5].
- R10: `bus_iack` equals modifier[4]. During an acknowledge cycle, the level given by `cpu_addr`[3:1] appears on `bus_addr`[3:1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register write selector |
| reg_wdata | input | 8 | Register write data |
| rd_sel | input | 3 | Register read selector |
| rd_data | output | 8 | Register read data (combinational) |
| cpu_hit | input | 1 | CPU access falls in the window |
| cpu_addr | input | 16 | CPU offset inside the window |
| cpu_wdata | input | 32 | CPU data lanes |
| cpu_be | input | 4 | CPU byte enables |
| cpu_super | input | 1 | Privileged access |
| cpu_prog | input | 1 | Program (instruction) access |
| bus_valid | output | 1 | Composed cycle present |
| bus_addr | output | 32 | Composed bus address |
| bus_am | output | 6 | Address modifier |
| bus_data | output | 32 | Lane-ordered data |
| bus_be | output | 4 | Lane-ordered byte enables |
| bus_iack | output | 1 | Interrupt acknowledge cycle |
| bus_big | output | 1 | Byte reversal active |

## Verification
The bench targets a register write and a window hit in the same cycle. A design that forwarded the new value would emit a page the software had not yet set. It checks all three alias selectors against one another. A design that decoded only one of them would leave the middle page stale after a write through another, and one that decoded too widely would let writes to the unused selectors 5 to 7 corrupt the page. Reversed lanes are checked with sparse byte enables, so a design that swapped the data but not the enables, or drove disabled lanes, shows up at once. The hardware-filled modifier bits are checked under all four privilege and kind combinations, which catches a design that swaps their positions.

// File: rtl/pgbus_pkg.sv
// Shared types and codes for the paged bus composer.
// Assumes an 8-bit register write port and a 3-bit selector space.
package pgbus_pkg;
    localparam int REG_W = 8;
    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_TOP  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_MOD  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_MIDA = 3'd2;
    localparam logic [SEL_W-1:0] SEL_MIDB = 3'd3;
    localparam logic [SEL_W-1:0] SEL_MIDC = 3'd4;

    // Modifier register layout, bit 7 down to bit 0
    typedef struct packed {
        logic [1:0] addr_hi2;  // bus address bits 23..22
        logic       big;       // byte reversal select
        logic       iack;      // interrupt acknowledge cycle
        logic [3:0] am_sw;     // AM5, AM4, AM2, AM1
    } mod_t;
endpackage

// File: rtl/pgbus_regs.sv
// Page and modifier register file.
// Holds the top page, modifier and middle page registers. Three selectors
// alias the middle page. Unused selectors are ignored on write and read as 0.
// Assumes writes are single-cycle strobes.
module pgbus_regs
    import pgbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [REG_W-1:0] wdata,
    input  logic [SEL_W-1:0] rsel,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] top_pg,
    output mod_t             mod_r,
    output logic [REG_W-1:0] mid_pg
);
    logic mid_hit_w;
    logic mid_hit_r;

    // Decode the aliased middle page selectors
    always_comb begin
        mid_hit_w = (wsel == SEL_MIDA) || (wsel == SEL_MIDB) || (wsel == SEL_MIDC);
        mid_hit_r = (rsel == SEL_MIDA) || (rsel == SEL_MIDB) || (rsel == SEL_MIDC);
    end

    // Register storage updated by the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_pg <= '0;
            mod_r  <= '0;
            mid_pg <= '0;
        end else if (we) begin
            if (wsel == SEL_TOP) top_pg <= wdata;
            if (wsel == SEL_MOD) mod_r  <= mod_t'(wdata);
            if (mid_hit_w)       mid_pg <= wdata;
        end
    end

    // Combinational read mux
    always_comb begin
        if (rsel == SEL_TOP)      rdata = top_pg;
        else if (rsel == SEL_MOD) rdata = REG_W'(mod_r);
        else if (mid_hit_r)       rdata = mid_pg;
        else                      rdata = '0;
    end

    // R3: a write through any alias lands in the middle page
    a_r3_alias_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && mid_hit_w) |=> (mid_pg == $past(wdata)));

    // R4: unused selectors leave all registers untouched
    a_r4_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wsel > SEL_MIDC) |=> ($stable(top_pg) && $stable(mod_r) && $stable(mid_pg)));
endmodule

// File: rtl/pgbus_addr.sv
// Address and modifier composer.
// Splices the page registers with the CPU offset and fills the two
// hardware-generated modifier bits from the privilege and kind inputs.
// Assumes ADDR_W = 8 + 2 + MID_W + OFF_W.
module pgbus_addr
    import pgbus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [REG_W-1:0]  top_pg,
    input  mod_t              mod_r,
    input  logic [REG_W-1:0]  mid_pg,
    input  logic [OFF_W-1:0]  off,
    input  logic              super_i,
    input  logic              prog_i,
    output logic [ADDR_W-1:0] addr,
    output logic [5:0]        am
);
    localparam int MID_W = ADDR_W - REG_W - 2 - OFF_W;

    // Concatenate page fields with the CPU offset
    always_comb addr = {top_pg, mod_r.addr_hi2, mid_pg[MID_W-1:0], off};

    // Merge the software and hardware modifier bits
    always_comb am = {mod_r.am_sw[3], mod_r.am_sw[2], super_i,
                      mod_r.am_sw[1], mod_r.am_sw[0], prog_i};
endmodule

// File: rtl/pgbus_swap.sv
// Byte lane steering.
// Passes enabled lanes straight through, or reverses lane order when big
// is set. Enables follow their bytes, and disabled lanes are driven 0.
module pgbus_swap #(
    parameter int LANES = 4
) (
    input  logic               big,
    input  logic [LANES*8-1:0] din,
    input  logic [LANES-1:0]   bein,
    output logic [LANES*8-1:0] dout,
    output logic [LANES-1:0]   beout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int MIRROR = LANES - 1 - g;
        logic       en;
        logic [7:0] byte_v;
        // Pick the source lane for this output lane
        always_comb begin
            en     = big ? bein[MIRROR] : bein[g];
            byte_v = big ? din[MIRROR*8 +: 8] : din[g*8 +: 8];
            beout[g]       = en;
            dout[g*8 +: 8] = en ? byte_v : 8'h00;
        end
    end
endmodule

// File: rtl/pgbus_compose.sv
// Paged bus address and modifier composer, top level.
// On a window hit, registers the composed address, modifier, lane-ordered
// data and cycle flags, one clock after the hit. Register writes take
// effect after the edge, so a same-cycle hit uses the previous values.
module pgbus_compose
    import pgbus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LANES  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [2:0]          reg_sel,
    input  logic [7:0]          reg_wdata,
    input  logic [2:0]          rd_sel,
    output logic [7:0]          rd_data,
    input  logic                cpu_hit,
    input  logic [OFF_W-1:0]    cpu_addr,
    input  logic [LANES*8-1:0]  cpu_wdata,
    input  logic [LANES-1:0]    cpu_be,
    input  logic                cpu_super,
    input  logic                cpu_prog,
    output logic                bus_valid,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [5:0]          bus_am,
    output logic [LANES*8-1:0]  bus_data,
    output logic [LANES-1:0]    bus_be,
    output logic                bus_iack,
    output logic                bus_big
);
    logic [REG_W-1:0]  top_pg;
    logic [REG_W-1:0]  mid_pg;
    mod_t              mod_r;
    logic [ADDR_W-1:0] addr_c;
    logic [5:0]        am_c;
    logic [LANES*8-1:0] data_c;
    logic [LANES-1:0]  be_c;

    pgbus_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .wsel(reg_sel), .wdata(reg_wdata),
        .rsel(rd_sel), .rdata(rd_data), .top_pg(top_pg), .mod_r(mod_r), .mid_pg(mid_pg)
    );

    pgbus_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
        .top_pg(top_pg), .mod_r(mod_r), .mid_pg(mid_pg), .off(cpu_addr),
        .super_i(cpu_super), .prog_i(cpu_prog), .addr(addr_c), .am(am_c)
    );

    pgbus_swap #(.LANES(LANES)) u_swap (
        .big(mod_r.big), .din(cpu_wdata), .bein(cpu_be), .dout(data_c), .beout(be_c)
    );

    // Capture the composed cycle on a window hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_valid <= 1'b0;
            bus_addr  <= '0;
            bus_am    <= '0;
            bus_data  <= '0;
            bus_be    <= '0;
            bus_iack  <= 1'b0;
            bus_big   <= 1'b0;
        end else begin
            bus_valid <= cpu_hit;
            if (cpu_hit) begin
                bus_addr <= addr_c;
                bus_am   <= am_c;
                bus_data <= data_c;
                bus_be   <= be_c;
                bus_iack <= mod_r.iack;
                bus_big  <= mod_r.big;
            end
        end
    end

    // R5: valid follows the hit by one cycle
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |=> bus_valid);
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_hit |=> (!bus_valid && $stable(bus_addr) && $stable(bus_data)));
    // R6: low address bits come from the CPU offset
    a_r6_offset: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |=> (bus_addr[OFF_W-1:0] == $past(cpu_addr)));
    // R7: hardware-generated modifier bits
    a_r7_hw_am: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |=> (bus_am[3] == $past(cpu_super) && bus_am[0] == $past(cpu_prog)));
    // R9: lane steering keeps the number of enabled bytes
    a_r9_be_count: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |=> ($countones(bus_be) == $countones($past(cpu_be))));
endmodule

// File: tb/pgbus_compose_tb.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with the design on each falling edge.
module pgbus_compose_tb_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [2:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic        cpu_hit = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_super = 1'b0;
    logic        cpu_prog = 1'b0;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic [5:0]  bus_am;
    logic [31:0] bus_data;
    logic [3:0]  bus_be;
    logic        bus_iack;
    logic        bus_big;

    int checks = 0;
    int fails  = 0;
    bit in_rst = 1'b1;
    bit done   = 1'b0;

    // reference state
    logic [7:0]  m_top = 0, m_mod = 0, m_mid = 0;
    logic        e_valid = 0, e_iack = 0, e_big = 0;
    logic [31:0] e_addr = 0, e_data = 0;
    logic [5:0]  e_am = 0;
    logic [3:0]  e_be = 0;

    pgbus_compose dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
        .cpu_hit(cpu_hit), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_be(cpu_be), .cpu_super(cpu_super), .cpu_prog(cpu_prog),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_am(bus_am),
        .bus_data(bus_data), .bus_be(bus_be), .bus_iack(bus_iack), .bus_big(bus_big)
    );

    always #(PERIOD/2) clk = ~clk;

    // reference model: outputs use register values before this edge's write
    always @(posedge clk) begin
        if (!rst_n) begin
            m_top = 0; m_mod = 0; m_mid = 0;
            e_valid = 0; e_addr = 0; e_am = 0; e_data = 0; e_be = 0;
            e_iack = 0; e_big = 0;
        end else begin
            e_valid = cpu_hit;
            if (cpu_hit) begin
                e_addr = {m_top, m_mod[7:6], m_mid[5:0], cpu_addr};
                e_am   = {m_mod[3], m_mod[2], cpu_super, m_mod[1], m_mod[0], cpu_prog};
                e_iack = m_mod[4];
                e_big  = m_mod[5];
                for (int i = 0; i < 4; i++) begin
                    int src;
                    src = m_mod[5] ? 3 - i : i;
                    e_be[i] = cpu_be[src];
                    e_data[i*8 +: 8] = cpu_be[src] ? cpu_wdata[src*8 +: 8] : 8'h00;
                end
            end
            if (reg_we) begin
                case (reg_sel)
                    3'd0: m_top = reg_wdata;
                    3'd1: m_mod = reg_wdata;
                    3'd2, 3'd3, 3'd4: m_mid = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] m_read(input logic [2:0] s);
        case (s)
            3'd0: return m_top;
            3'd1: return m_mod;
            3'd2, 3'd3, 3'd4: return m_mid;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on the falling edge
    task automatic tick();
        string rt;
        @(negedge clk);
        if (in_rst) begin
            chk("R1 rd_data", 32'(rd_data), 0);
            chk("R1 valid", 32'(bus_valid), 0);
            chk("R1 addr", bus_addr, 0);
            chk("R1 am/data/be", {bus_am, bus_be, bus_iack, bus_big}, 0);
            chk("R1 data", bus_data, 0);
        end else begin
            rt = (rd_sel < 3'd2) ? "R2 read" : (rd_sel < 3'd5) ? "R3 alias read" : "R4 unused read";
            chk(rt, 32'(rd_data), 32'(m_read(rd_sel)));
            chk("R5 valid", 32'(bus_valid), 32'(e_valid));
            chk("R6 addr", bus_addr, e_addr);
            chk("R7 am", 32'(bus_am), 32'(e_am));
            chk(e_big ? "R9 reversed data" : "R8 straight data", bus_data, e_data);
            chk(e_big ? "R9 reversed be" : "R8 straight be", 32'(bus_be), 32'(e_be));
            chk("R9 big flag", 32'(bus_big), 32'(e_big));
            chk("R10 iack", 32'(bus_iack), 32'(e_iack));
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        reg_we = 1; reg_sel = s; reg_wdata = d; tick(); reg_we = 0;
    endtask

    task automatic hit(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be,
                       input logic sup, input logic prg);
        cpu_hit = 1; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        cpu_super = sup; cpu_prog = prg; tick(); cpu_hit = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        rst_n = 1; in_rst = 0;
        tick();
        // R2: top page and modifier, read back
        wr(3'd0, 8'hA5); rd_sel = 0; tick();
        wr(3'd1, 8'h0D); rd_sel = 1; tick();
        // R3: write via one alias, read via the others
        wr(3'd3, 8'h2A);
        for (int s = 2; s <= 4; s++) begin rd_sel = 3'(s); tick(); end
        wr(3'd4, 8'h15); rd_sel = 2; tick();
        // R4: unused selectors ignored and read as 0
        for (int s = 5; s <= 7; s++) begin wr(3'(s), 8'hFF); rd_sel = 3'(s); tick(); end
        for (int s = 0; s <= 4; s++) begin rd_sel = 3'(s); tick(); end
        // R6/R7/R8: little-endian, all privilege and kind combinations
        for (int k = 0; k < 4; k++) hit(16'h1234 + 16'(k), 32'h44332211, 4'hF, k[1], k[0]);
        hit(16'hBEEF, 32'hDDCCBBAA, 4'b0101, 0, 1);
        // R5: write and hit in the same cycle uses the old top page
        reg_we = 1; reg_sel = 0; reg_wdata = 8'h3C;
        hit(16'h0F0F, 32'h01020304, 4'hF, 1, 0); reg_we = 0;
        hit(16'h0F0F, 32'h01020304, 4'hF, 1, 0);
        tick(); tick();
        // 16-bit address-space setup: bits 23..22 set to 11
        wr(3'd1, 8'hCD); hit(16'h8000, 32'h0, 4'h0, 1, 1);
        // R9: reversed lanes with sparse enables
        wr(3'd1, 8'h2D);
        hit(16'h0004, 32'h44332211, 4'hF, 1, 0);
        hit(16'h0008, 32'h44332211, 4'b0010, 1, 0);
        hit(16'h000C, 32'h44332211, 4'b1001, 0, 1);
        // R10: interrupt acknowledge with level 5 on A3..A1
        wr(3'd1, 8'h12);
        hit(16'h000A, 32'h0, 4'b0001, 1, 0);
        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            reg_we    = ($urandom_range(0, 3) == 0);
            reg_sel   = 3'($urandom_range(0, 7));
            reg_wdata = 8'($urandom);
            rd_sel    = 3'($urandom_range(0, 7));
            cpu_hit   = ($urandom_range(0, 2) != 0);
            cpu_addr  = 16'($urandom);
            cpu_wdata = $urandom;
            cpu_be    = 4'($urandom);
            cpu_super = 1'($urandom);
            cpu_prog  = 1'($urandom);
            tick();
        end
        reg_we = 0; cpu_hit = 0;
        tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule